// File: doc/BRIEF.md
# Serial Interface Mode Select Latch

This block sits on the device side of a serial configuration port that can speak one of two protocols. It decides, once per powered session, which of the two the port will use. After power is applied, an internal hold-off counter stands in for the power-on reset. While that counter runs, all activity on the serial clock and enable lines is disregarded. Once the hold-off ends, the block watches both lines. The first line to show a rising edge decides the protocol. A rising clock selects the clock-first protocol. A rising enable selects the enable-first protocol.

The choice is latched and cannot change until supply-good drops, which models power removal, or the block is reset. Both serial lines are asynchronous to the system clock, so each passes through a synchronizer before its edges are detected. While no mode is latched, both protocol-engine enables stay low. This keeps the downstream engines idle. Every pin here is a plain control or status signal: there is no data stream and no handshake.

Top module: `ifsel_mode_latch`

## Requirements
- R1: While `rst_n` is low, `mode_valid`, `mode_enf`, `clk_first_en` and `en_first_en` are all 0.
- R2: A rising edge on `sck_i` or `sen_i` that is synchronized before `supply_good` has been high for `HOLDOFF_CYCLES` consecutive clock edges selects nothing. `mode_valid` stays 0 through the hold-off.
- R3: After the hold-off, a line that is already high, or that is held at a constant level, selects nothing. Only a low-to-high transition seen after the hold-off counts.
- R4: If `sck_i` rises first after the hold-off, the latched mode is clock-first, shown as `mode_enf` = 0.
- R5: If `sen_i` rises first after the hold-off, the latched mode is enable-first, shown as `mode_enf` = 1.
- R6: If both lines rise in the same system-clock cycle, enable-first wins (`mode_enf` = 1).
- R7: The decision timing is as follows. Suppose a line goes high between two clock edges. Counting from that point, `mode_valid` is still 0 after the second following rising clock edge. It is 1 after the third.
- R8: Once `mode_valid` is 1, further edges or levels on either line change neither `mode_valid` nor `mode_enf` while `supply_good` stays high.
- R9: `clk_first_en` is 1 exactly when a mode is latched and `mode_enf` = 0. `en_first_en` is 1 exactly when a mode is latched and `mode_enf` = 1. Both are 0 while `mode_valid` is 0.
- R10: When `supply_good` goes low, the next rising clock edge clears `mode_valid` and restarts the hold-off. A later power-up can then latch either mode again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_good | input | 1 | Digital supply is up. Low models power removal |
| sck_i | input | 1 | Serial clock line, asynchronous |
| sen_i | input | 1 | Serial enable line, asynchronous |
| mode_valid | output | 1 | A protocol has been latched for this session |
| mode_enf | output | 1 | Latched protocol: 0 clock-first, 1 enable-first |
| clk_first_en | output | 1 | Run enable for the clock-first protocol engine |
| en_first_en | output | 1 | Run enable for the enable-first protocol engine |

## Verification
The assertions assume that `supply_good` stays high for the whole of a session once it has risen. They also assume that each serial line holds a level for at least one system-clock cycle, so that every edge crosses the synchronizer as one clean transition. The stimulus changes lines only on falling clock edges and holds each level for one cycle or more. It places all glitching well before the hold-off ends, leaving a margin wider than the synchronizer delay. Selecting edges come well after the hold-off ends, so no edge lands exactly on its boundary.

// File: rtl/ifsel_pkg.sv
package ifsel_pkg;

  typedef enum logic {
    MODE_CLK_FIRST = 1'b0,
    MODE_EN_FIRST  = 1'b1
  } ifmode_e;

endpackage

// File: rtl/ifsel_sync.sv
module ifsel_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/ifsel_holdoff.sv
module ifsel_holdoff #(
  parameter int HOLDOFF_CYCLES = 450
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_good,
  output logic por_done
);

  localparam int CW = $clog2(HOLDOFF_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLDOFF_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      por_done <= 1'b0;
    end else if (!supply_good) begin
      cnt      <= '0;
      por_done <= 1'b0;
    end else if (!por_done) begin
      if (cnt == LAST) por_done <= 1'b1;
      else             cnt      <= cnt + 1'b1;
    end
  end

  // R10
  supply_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_good |=> !por_done);

endmodule

// File: rtl/ifsel_race.sv
module ifsel_race
  import ifsel_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    supply_good,
  input  logic    por_done,
  input  logic    sck_s,
  input  logic    sen_s,
  output logic    mode_valid,
  output ifmode_e mode
);

  logic sck_d, sen_d;
  logic sck_rise, sen_rise;

  // Previous-level registers track continuously, so a line that is
  // already high when the hold-off ends never looks like an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      sen_d <= 1'b0;
    end else begin
      sck_d <= sck_s;
      sen_d <= sen_s;
    end
  end

  assign sck_rise = sck_s & ~sck_d;
  assign sen_rise = sen_s & ~sen_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_valid <= 1'b0;
      mode       <= MODE_CLK_FIRST;
    end else if (!supply_good) begin
      mode_valid <= 1'b0;
      mode       <= MODE_CLK_FIRST;
    end else if (por_done && !mode_valid) begin
      if (sen_rise) begin
        mode_valid <= 1'b1;
        mode       <= MODE_EN_FIRST;
      end else if (sck_rise) begin
        mode_valid <= 1'b1;
        mode       <= MODE_CLK_FIRST;
      end
    end
  end

  // R2
  sel_after_por_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_valid) |-> $past(por_done));

  // R8
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_valid && supply_good) |=> (mode_valid && $stable(mode)));

  // R6
  tie_enf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_good && por_done && !mode_valid && sen_rise) |=> (mode == MODE_EN_FIRST));

  // R10
  drop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_good |=> !mode_valid);

endmodule

// File: rtl/ifsel_mode_latch.sv
module ifsel_mode_latch
  import ifsel_pkg::*;
#(
  parameter int HOLDOFF_CYCLES = 450,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_good,
  input  logic sck_i,
  input  logic sen_i,
  output logic mode_valid,
  output logic mode_enf,
  output logic clk_first_en,
  output logic en_first_en
);

  localparam int NLINES = 2;
  localparam int IDX_SCK = 0;
  localparam int IDX_SEN = 1;

  logic [NLINES-1:0] lines_raw, lines_s;
  logic              por_done;
  ifmode_e           mode;

  assign lines_raw[IDX_SCK] = sck_i;
  assign lines_raw[IDX_SEN] = sen_i;

  ifsel_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (lines_raw),
    .dout (lines_s)
  );

  ifsel_holdoff #(.HOLDOFF_CYCLES(HOLDOFF_CYCLES)) u_holdoff (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_good(supply_good),
    .por_done   (por_done)
  );

  ifsel_race u_race (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_good(supply_good),
    .por_done   (por_done),
    .sck_s      (lines_s[IDX_SCK]),
    .sen_s      (lines_s[IDX_SEN]),
    .mode_valid (mode_valid),
    .mode       (mode)
  );

  assign mode_enf     = (mode == MODE_EN_FIRST);
  assign clk_first_en = mode_valid && (mode == MODE_CLK_FIRST);
  assign en_first_en  = mode_valid && (mode == MODE_EN_FIRST);

  // R2
  valid_needs_por_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !por_done |-> !mode_valid);

  // R9
  eng_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clk_first_en, en_first_en}));

endmodule

// File: tb/sim_ifsel_mode_latch.sv
module sim_ifsel_mode_latch;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 64;

  // vector: {first[1:0] (0 sck, 1 sen, 2 both), other_static_high, exp_enf}
  localparam int NVEC = 5;
  localparam logic [3:0] VECS [NVEC] = '{
    4'b00_0_0,  // R4 sck first
    4'b01_0_1,  // R5 sen first
    4'b10_0_1,  // R6 same cycle
    4'b00_1_0,  // R3 sck first, sen held high through hold-off
    4'b01_1_1   // R3 sen first, sck held high through hold-off
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_good = 1'b0;
  logic sck_i = 1'b0;
  logic sen_i = 1'b0;
  logic mode_valid, mode_enf, clk_first_en, en_first_en;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ifsel_mode_latch #(.HOLDOFF_CYCLES(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_good(supply_good),
    .sck_i(sck_i), .sen_i(sen_i),
    .mode_valid(mode_valid), .mode_enf(mode_enf),
    .clk_first_en(clk_first_en), .en_first_en(en_first_en)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] outs();
    return {mode_valid, mode_enf, clk_first_en, en_first_en};
  endfunction

  // power up with glitches during hold-off; leave lines at given levels
  task automatic power_up(input logic sck_lvl, input logic sen_lvl);
    @(negedge clk);
    supply_good = 1'b0; sck_i = 1'b0; sen_i = 1'b0;
    cyc(3);
    supply_good = 1'b1;
    for (int k = 0; k < HOLD - 20; k++) begin
      if (k % 2 == 0) sck_i = ~sck_i;
      if (k % 3 == 0) sen_i = ~sen_i;
      @(negedge clk);
    end
    check("R2 pre-hold-off glitches", {mode_valid, 3'b000}, 4'b0000);
    sck_i = sck_lvl; sen_i = sen_lvl;
    cyc(35);
    check("R3 static levels after hold-off", outs(), 4'b0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state
    cyc(3);
    check("R1 reset outputs", outs(), 4'b0000);
    supply_good = 1'b1; sck_i = 1'b1; sen_i = 1'b1;
    cyc(2);
    check("R1 held in reset", outs(), 4'b0000);
    sck_i = 1'b0; sen_i = 1'b0;
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] first;
      logic       oth, exp_enf;
      first   = VECS[v][3:2];
      oth     = VECS[v][1];
      exp_enf = VECS[v][0];
      power_up(first == 2'd1 ? oth : 1'b0, first == 2'd0 ? oth : 1'b0);
      if (first != 2'd1) sck_i = 1'b1;
      if (first != 2'd0) sen_i = 1'b1;
      cyc(2);
      check("R7 not yet valid after two edges", {mode_valid, 3'b000}, 4'b0000);
      cyc(1);
      check(exp_enf ? "R5/R6 enable-first latched" : "R4 clock-first latched",
            {mode_valid, mode_enf, 2'b00}, {1'b1, exp_enf, 2'b00});
      check("R9 engine enables", {2'b00, clk_first_en, en_first_en},
            {2'b00, ~exp_enf, exp_enf});
      // R8 later activity on both lines
      for (int t = 0; t < 6; t++) begin
        sck_i = ~sck_i;
        if (t % 2 == 1) sen_i = ~sen_i;
        cyc(2);
      end
      sck_i = 1'b0; sen_i = 1'b0; cyc(2);
      sck_i = 1'b1; sen_i = 1'b1; cyc(5);
      check("R8 mode locked", outs(), {1'b1, exp_enf, ~exp_enf, exp_enf});
    end

    // R10 supply drop clears
    supply_good = 1'b0;
    cyc(1);
    check("R10 cleared on supply drop", {mode_valid, 1'b0, clk_first_en, en_first_en}, 4'b0000);
    // R10 re-select other mode after new power-up
    power_up(1'b0, 1'b0);
    sck_i = 1'b1;
    cyc(4);
    check("R10 reselect clock-first", outs(), 4'b1010);

    // R1 async reset clears a latched mode
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", outs(), 4'b0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule